// File: doc/BRIEF.md
# Delayed-Parity Address/Command Checker

This block watches the address, bank and command lines that a host sends to a registered memory buffer. It checks that their parity is correct. On every clock edge it captures those lines and folds them into a single even-parity bit. It also notes whether any chip select was asserted in that cycle. The host sends the matching parity bit one clock later. The block compares the two. If they disagree for a cycle in which a chip select was active, it pulls its error pin low for one clock.

The error pin is modelled as an open-drain output. One output is the pull-down enable and a second output is the resulting pin level, so a board-level wired-AND of several checkers can be formed outside. Clock-enable, on-die-termination and chip-select lines enter the block but never enter the parity sum. Cycles with no chip select asserted are never reported, whatever arrives on the parity input.

Top module: `addr_cmd_parity_chk`

## Requirements
- R1: Even parity. The parity covering one cycle is the XOR of every bit of `addr_i`, `bank_i` and `cmd_i`. A qualified cycle is correct when `par_i` equals that XOR.
- R2: The parity bit for data captured at clock edge k is taken from `par_i` at edge k+1. The resulting error state is visible on the outputs right after edge k+1.
- R3: `err_n_o` is always the inverse of `err_oe_o`. The pin is either released (`err_oe_o`=0, `err_n_o`=1) or pulled low (`err_oe_o`=1, `err_n_o`=0), and it is never driven high.
- R4: `cke_i`, `odt_i` and `cs_n_i` do not contribute to the parity. Changing them while the other inputs stay the same never changes whether an error is reported.
- R5: A cycle in which every bit of the active-low `cs_n_i` is 1 is never checked. No error follows it, whatever value `par_i` takes one clock later.
- R6: While `rst` is high at a clock edge, the captured parity and qualifier are cleared and the pin is released. A cycle captured before or during reset is not reported after reset ends.
- R7: Each mismatching qualified cycle pulls the pin low for exactly one clock. Consecutive mismatching cycles keep it low without a gap.
- R8: A cycle is qualified when any one or more bits of `cs_n_i` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Address lines, covered by parity |
| bank_i | input | BANK_W | Bank lines, covered by parity |
| cmd_i | input | CMD_W | Command strobes, covered by parity |
| cs_n_i | input | CS_W | Active-low chip selects; qualify the check, excluded from parity |
| cke_i | input | CKE_W | Clock-enable lines, excluded from parity |
| odt_i | input | ODT_W | Termination-control lines, excluded from parity |
| par_i | input | 1 | Host parity bit, one clock after the data it covers |
| err_oe_o | output | 1 | Open-drain pull-down enable; 1 pulls the error pin low |
| err_n_o | output | 1 | Resulting active-low error pin level |

## Verification
The hardest situation to reach is one where the skewed parity input and the qualifier disagree about which cycle they belong to. Examples are a qualified mismatch followed directly by an unqualified cycle that carries a wrong parity bit, and a mismatch whose parity bit lands on a reset edge. The stimulus reaches these cases by driving each cycle's parity bit one step behind its data. It then deliberately corrupts the parity bit on selected steps. This makes it possible to place a corruption next to a deselected cycle, inside a run of corrupted cycles, or on the cycle where reset rises.

// File: rtl/apc_pkg.sv
package apc_pkg;
  // Open-drain pin state: pulling means the shared error line goes low.
  typedef enum logic {
    OD_RELEASE = 1'b0,
    OD_PULL    = 1'b1
  } od_drive_e;
endpackage

// File: rtl/apc_xor_tree.sv
module apc_xor_tree #(
  parameter int W       = 22,
  parameter int GROUP_W = 4
) (
  input  logic [W-1:0] vec_i,
  output logic         par_o
);
  localparam int NG = (W + GROUP_W - 1) / GROUP_W;
  localparam int PW = NG * GROUP_W;

  logic [PW-1:0] padded;
  logic [NG-1:0] grp;

  always_comb begin
    padded        = '0;
    padded[W-1:0] = vec_i;
  end

  // First level: one XOR per group of GROUP_W leaves.
  generate
    for (genvar g = 0; g < NG; g++) begin : g_grp
      assign grp[g] = ^padded[g*GROUP_W +: GROUP_W];
    end
  endgenerate

  // Second level: fold the group results.
  assign par_o = ^grp;
endmodule

// File: rtl/apc_capture.sv
module apc_capture #(
  parameter int ADDR_W  = 16,
  parameter int BANK_W  = 3,
  parameter int CMD_W   = 3,
  parameter int CS_W    = 4,
  parameter int GROUP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [CS_W-1:0]   cs_n_i,
  output logic              par_q,
  output logic              qual_q
);
  localparam int LEAF_W = ADDR_W + BANK_W + CMD_W;

  logic [LEAF_W-1:0] leaves;
  logic              leaf_par;

  assign leaves = {addr_i, bank_i, cmd_i};

  apc_xor_tree #(.W(LEAF_W), .GROUP_W(GROUP_W)) u_tree (
    .vec_i (leaves),
    .par_o (leaf_par)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      par_q  <= 1'b0;
      qual_q <= 1'b0;
    end else begin
      par_q  <= leaf_par;
      qual_q <= ~&cs_n_i;
    end
  end

  // R5: a fully deselected cycle never becomes a checked cycle
  p_idle_cs_no_qual_r5: assert property (@(posedge clk) disable iff (rst)
    (&cs_n_i) |=> !qual_q);

  // R8: any single active chip select qualifies the cycle
  p_any_cs_qual_r8: assert property (@(posedge clk) disable iff (rst)
    (!(&cs_n_i)) |=> qual_q);
endmodule

// File: rtl/apc_compare.sv
module apc_compare (
  input  logic par_q_i,
  input  logic qual_i,
  input  logic par_i,
  output logic mismatch_o
);
  // Even parity: the captured XOR plus the host bit must sum to zero.
  assign mismatch_o = qual_i & (par_q_i ^ par_i);
endmodule

// File: rtl/apc_odrv.sv
module apc_odrv
  import apc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic mismatch_i,
  output logic err_oe_o,
  output logic err_n_o
);
  od_drive_e drive_q;
  logic      level_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q <= OD_RELEASE;
      level_q <= 1'b1;
    end else begin
      drive_q <= mismatch_i ? OD_PULL : OD_RELEASE;
      level_q <= ~mismatch_i;
    end
  end

  assign err_oe_o = (drive_q == OD_PULL);
  assign err_n_o  = level_q;

  // R6: a reset edge always leaves the pin released
  p_release_after_reset_r6: assert property (@(posedge clk)
    rst |=> (err_n_o && !err_oe_o));

  // R7: a mismatch pulls the pin for the following clock
  p_pull_on_mismatch_r7: assert property (@(posedge clk) disable iff (rst)
    mismatch_i |=> err_oe_o);

  // R7: no mismatch means released in the following clock
  p_release_no_mismatch_r7: assert property (@(posedge clk) disable iff (rst)
    !mismatch_i |=> !err_oe_o);

  // R3: enable and pin level never agree
  p_pin_pair_r3: assert property (@(posedge clk) disable iff (rst)
    (err_oe_o ^ err_n_o));
endmodule

// File: rtl/addr_cmd_parity_chk.sv
module addr_cmd_parity_chk #(
  parameter int ADDR_W  = 16,
  parameter int BANK_W  = 3,
  parameter int CMD_W   = 3,
  parameter int CS_W    = 4,
  parameter int CKE_W   = 2,
  parameter int ODT_W   = 2,
  parameter int GROUP_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic [CMD_W-1:0]  cmd_i,
  input  logic [CS_W-1:0]   cs_n_i,
  input  logic [CKE_W-1:0]  cke_i,
  input  logic [ODT_W-1:0]  odt_i,
  input  logic              par_i,
  output logic              err_oe_o,
  output logic              err_n_o
);
  logic par_q;
  logic qual_q;
  logic mismatch;

  apc_capture #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CMD_W(CMD_W),
    .CS_W(CS_W), .GROUP_W(GROUP_W)
  ) u_cap (
    .clk    (clk),
    .rst    (rst),
    .addr_i (addr_i),
    .bank_i (bank_i),
    .cmd_i  (cmd_i),
    .cs_n_i (cs_n_i),
    .par_q  (par_q),
    .qual_q (qual_q)
  );

  apc_compare u_cmp (
    .par_q_i    (par_q),
    .qual_i     (qual_q),
    .par_i      (par_i),
    .mismatch_o (mismatch)
  );

  apc_odrv u_drv (
    .clk        (clk),
    .rst        (rst),
    .mismatch_i (mismatch),
    .err_oe_o   (err_oe_o),
    .err_n_o    (err_n_o)
  );

  // R4: moving only the control lines leaves the captured parity unchanged
  p_ctrl_excluded_r4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(addr_i) && $stable(bank_i) && $stable(cmd_i)
     && !$stable({cke_i, odt_i, cs_n_i})) |=> $stable(par_q));
endmodule

// File: tb/sim_addr_cmd_parity_chk.sv
module sim_addr_cmd_parity_chk;
  localparam int ADDR_W = 16;
  localparam int BANK_W = 3;
  localparam int CMD_W  = 3;
  localparam int CS_W   = 4;
  localparam int CKE_W  = 2;
  localparam int ODT_W  = 2;

  typedef struct {
    bit    exp_err;
    int    due;
    string tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [BANK_W-1:0] bank = '0;
  logic [CMD_W-1:0]  cmd  = '0;
  logic [CS_W-1:0]   cs_n = '1;
  logic [CKE_W-1:0]  cke  = '0;
  logic [ODT_W-1:0]  odt  = '0;
  logic              par  = 1'b0;
  logic              err_oe;
  logic              err_n;

  int    checks = 0;
  int    errors = 0;
  int    cyc    = 0;
  bit    finished = 0;
  item_t sb[$];

  bit prev_par  = 0;
  bit prev_qual = 0;

  addr_cmd_parity_chk #(
    .ADDR_W(ADDR_W), .BANK_W(BANK_W), .CMD_W(CMD_W),
    .CS_W(CS_W), .CKE_W(CKE_W), .ODT_W(ODT_W)
  ) u0 (
    .clk(clk), .rst(rst), .addr_i(addr), .bank_i(bank), .cmd_i(cmd),
    .cs_n_i(cs_n), .cke_i(cke), .odt_i(odt), .par_i(par),
    .err_oe_o(err_oe), .err_n_o(err_n)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // One step at a falling edge: the parity bit for the previous step's data
  // (optionally corrupted), then this step's data.
  task automatic step(input logic [ADDR_W-1:0] a, input logic [BANK_W-1:0] b,
                      input logic [CMD_W-1:0] c, input logic [CS_W-1:0] s,
                      input logic [CKE_W-1:0] k, input logic [ODT_W-1:0] o,
                      input bit flip, input bit r, input string tag);
    item_t it;
    @(negedge clk);
    rst = r;
    par = prev_par ^ flip;
    it.exp_err = prev_qual && flip && !r;
    it.due     = cyc + 1;
    it.tag     = tag;
    sb.push_back(it);
    addr = a; bank = b; cmd = c; cs_n = s; cke = k; odt = o;
    prev_par  = ^{a, b, c};
    prev_qual = !(&s) && !r;
  endtask

  // Monitor: compare scoreboard items that fall due after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        item_t it;
        it = sb.pop_front();
        check(it.due == cyc, {it.tag, " timing"}, it.due, cyc);
        check(err_oe == it.exp_err, it.tag, err_oe, it.exp_err);
        check(err_n == !err_oe, "R3 pin pair", err_n, !err_oe);
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // reset
    for (int i = 0; i < 3; i++) step('0, '0, '0, '1, '0, '0, 0, 1, "R6 in reset");
    @(posedge clk); #2;
    check(err_n == 1'b1 && err_oe == 1'b0, "R6 reset state", {err_oe, err_n}, 2'b01);

    // R1: correct parity on varied patterns gives no error
    step(16'hA5C3, 3'd5, 3'b011, 4'b1110, 2'b11, 2'b00, 0, 0, "R1 lead");
    step(16'h0001, 3'd0, 3'b111, 4'b1101, 2'b01, 2'b10, 0, 0, "R1 good A5C3");
    step(16'hFFFF, 3'd7, 3'b000, 4'b0000, 2'b00, 2'b11, 0, 0, "R1 good 0001");
    step(16'h1234, 3'd2, 3'b101, 4'b1011, 2'b10, 2'b01, 0, 0, "R1 good FFFF");
    // R1/R2: walking one with corrupted parity bit, one step late
    for (int i = 0; i < ADDR_W; i++)
      step(16'(1 << i), 3'd0, 3'b000, 4'b1110, 2'b11, 2'b00, 1, 0, "R2 late parity");
    step('0, '0, '0, 4'b1110, 2'b11, 2'b00, 1, 0, "R7 run of errors");
    step('0, '0, '0, 4'b1110, 2'b11, 2'b00, 0, 0, "R7 run of errors");
    step('0, '0, '0, 4'b1110, 2'b11, 2'b00, 0, 0, "R7 released after run");
    // R8: each single chip select qualifies
    for (int i = 0; i < CS_W; i++)
      step(16'h00F0, 3'd1, 3'b010, 4'(~(1 << i)), 2'b00, 2'b00, 0, 0, "R8 lead");
    for (int i = 0; i < CS_W; i++)
      step(16'h0F00, 3'd3, 3'b001, 4'(~(1 << i)), 2'b00, 2'b00, 1, 0, "R8 single cs");
    // R5: deselected cycles are never reported, even with a wrong bit
    step(16'h0F00, 3'd3, 3'b001, 4'b1111, 2'b11, 2'b11, 1, 0, "R8 last cs");
    step(16'h7777, 3'd6, 3'b110, 4'b1111, 2'b01, 2'b10, 1, 0, "R5 deselected");
    step(16'h7777, 3'd6, 3'b110, 4'b0111, 2'b01, 2'b10, 1, 0, "R5 deselected");
    // R4: same data, control lines varied, correct parity
    step(16'h7777, 3'd6, 3'b110, 4'b1110, 2'b10, 2'b01, 1, 0, "R4 qualified after R5");
    step(16'h7777, 3'd6, 3'b110, 4'b1101, 2'b01, 2'b11, 0, 0, "R4 ctrl excluded");
    step(16'h7777, 3'd6, 3'b110, 4'b0011, 2'b11, 2'b00, 0, 0, "R4 ctrl excluded");
    // R7: isolated pulse
    step(16'h8001, 3'd4, 3'b100, 4'b1110, 2'b00, 2'b00, 0, 0, "R4 ctrl excluded");
    step(16'h8001, 3'd4, 3'b100, 4'b1110, 2'b00, 2'b00, 1, 0, "R7 single pulse");
    step(16'h8001, 3'd4, 3'b100, 4'b1110, 2'b00, 2'b00, 0, 0, "R7 pulse ends");
    // R6: a corrupted parity bit landing on a reset edge is not reported
    step(16'h4242, 3'd2, 3'b010, 4'b1110, 2'b00, 2'b00, 0, 0, "R7 quiet");
    step(16'h4242, 3'd2, 3'b010, 4'b1110, 2'b00, 2'b00, 1, 1, "R6 mismatch at reset");
    step(16'h4242, 3'd2, 3'b010, 4'b1110, 2'b00, 2'b00, 1, 0, "R6 captured in reset");
    step(16'h4242, 3'd2, 3'b010, 4'b1111, 2'b00, 2'b00, 0, 0, "R6 normal after reset");
    step('0, '0, '0, 4'b1111, 2'b00, 2'b00, 0, 0, "R5 drain");
    repeat (4) @(posedge clk);
    #3;
    check(sb.size() == 0, "scoreboard drained", sb.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule